// File: doc/BRIEF.md
# Vertical Field Detector

This block watches a vertical timing input and a horizontal line reference and reports where each field begins, whether that field is odd or even, and where the first usable line of the field lies. The vertical input is either a sync pulse, where one selectable transition marks the field start, or a level-type odd/even signal, where every transition marks a new field. A static line offset holds back the first usable line. The offset counts only lines during which a pixel-qualifier pulse was seen.

All inputs are sampled into the pixel clock domain by one register stage and then edge-detected. Every output is registered. An input change driven between two clock edges therefore shows up on the outputs after the second rising edge that follows it. The configuration inputs are expected to stay static while the block runs. The block has no data stream, so it has no valid/ready handshake and no back-pressure: all pins are plain control and status levels or pulses.

Top module: `vfd_top`

## Requirements
- R1: In sync-pulse mode (`cfg_level_mode`=0) the selected edge of `vsync_in` (rising when `cfg_fall_edge`=0, falling when 1) produces a one-cycle `field_start` pulse two clock edges after the input changes. The other edge produces none.
- R2: In sync-pulse mode `field_odd` takes the level of `href_in` at the selected edge: 1 (odd) if HREF was high, 0 (even) if low.
- R3: In level mode (`cfg_level_mode`=1) both edges of `vsync_in` produce `field_start`, and `field_odd` becomes the new level of `vsync_in` XOR `cfg_fall_edge`.
- R4: A line is counted at the falling edge of `href_in` only if at least one `pix_qual_in` pulse was seen while HREF was high. A line without qualifiers leaves the count and `line_valid` unchanged.
- R5: A field start with a non-zero offset clears `line_valid` and restarts the line count.
- R6: With `cfg_line_offset`=N>0, `line_valid` rises and `first_line` pulses for one cycle when the N-th qualified line of the field ends. The window then stays open, with no further `first_line`, until the next field start.
- R7: With `cfg_line_offset`=0, `line_valid` rises and `first_line` pulses together with `field_start`.
- R8: Before the first field start after reset, no line is counted and `line_valid` stays 0.
- R9: After reset, `field_start`, `field_odd`, `first_line` and `line_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync_in | input | 1 | Vertical timing input (sync pulse or odd/even level) |
| href_in | input | 1 | Horizontal reference, high during the active part of a line |
| pix_qual_in | input | 1 | Pixel qualifier, high for a qualified pixel |
| cfg_fall_edge | input | 1 | 0: rising edge active, 1: falling edge active |
| cfg_level_mode | input | 1 | 0: sync-pulse input, 1: odd/even level input |
| cfg_line_offset | input | OFS_W | Qualified lines between field start and first valid line |
| field_start | output | 1 | One-cycle pulse at each field start |
| field_odd | output | 1 | Field identity, 1 = odd |
| first_line | output | 1 | One-cycle pulse when the first valid line begins |
| line_valid | output | 1 | High from the first valid line to the next field start |

## Verification
A wrong edge selection or a stale synchroniser stage shows at the ports as a missing, doubled or early `field_start` within two cycles of the vertical transition, and a wrong field identity is visible on `field_odd` at the same moment. A line counter that is off by one, or that counts unqualified lines, shows up as `line_valid` and `first_line` rising one line early or late. This is visible two cycles after the HREF falling edge of the affected line. A window that fails to close stays visible until the next field start.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  // bit positions inside the synchronised timing vector
  localparam int unsigned SIG_V  = 0;
  localparam int unsigned SIG_H  = 1;
  localparam int unsigned N_SIGS = 2;
endpackage

// File: rtl/vfd_edge_sync.sv
module vfd_edge_sync #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] now,
  output logic [N-1:0] prev,
  output logic         primed
);
  logic [N-1:0] stage1, stage2;
  logic         warm1, warm2;

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stage1[i] <= 1'b0;
          stage2[i] <= 1'b0;
        end else begin
          stage1[i] <= din[i];
          stage2[i] <= stage1[i];
        end
      end
      assign now[i]  = stage1[i];
      assign prev[i] = stage2[i];
    end
  endgenerate

  // edges are trusted only once both stages hold sampled data
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      warm1 <= 1'b0;
      warm2 <= 1'b0;
    end else begin
      warm1 <= 1'b1;
      warm2 <= warm1;
    end
  end
  assign primed = warm2;

  // R8: no transition is reported before the pipeline has filled
  a_r8_primed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    primed |=> primed);
endmodule

// File: rtl/vfd_field_phase.sv
module vfd_field_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic primed,
  input  logic v_now,
  input  logic v_prev,
  input  logic h_now,
  input  logic cfg_fall_edge,
  input  logic cfg_level_mode,
  output logic start_evt,
  output logic field_start,
  output logic field_odd
);
  logic v_rise, v_fall;

  assign v_rise = primed &  v_now & ~v_prev;
  assign v_fall = primed & ~v_now &  v_prev;

  always_comb begin
    if (cfg_level_mode) start_evt = v_rise | v_fall;
    else if (cfg_fall_edge) start_evt = v_fall;
    else start_evt = v_rise;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field_start <= 1'b0;
      field_odd   <= 1'b0;
    end else begin
      field_start <= start_evt;
      if (start_evt) begin
        if (cfg_level_mode) field_odd <= v_now ^ cfg_fall_edge;
        else field_odd <= h_now;
      end
    end
  end

  // R1: in sync-pulse mode the inactive edge never starts a field
  a_r1_inactive_edge_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_level_mode && (cfg_fall_edge ? v_rise : v_fall)) |=> !field_start);
  // R3: in level mode any transition starts a field
  a_r3_level_any_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_level_mode && (v_rise || v_fall)) |=> field_start);
endmodule

// File: rtl/vfd_line_gate.sv
module vfd_line_gate #(
  parameter int unsigned OFS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             primed,
  input  logic             h_now,
  input  logic             h_prev,
  input  logic             pix_qual_in,
  input  logic             start_evt,
  input  logic [OFS_W-1:0] cfg_line_offset,
  output logic             line_valid,
  output logic             first_line
);
  localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

  logic             qual_s;
  logic             seen;
  logic             armed;
  logic [OFS_W-1:0] cnt;
  logic             h_fall, line_done;

  assign h_fall    = primed & ~h_now & h_prev;
  assign line_done = h_fall & seen & armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qual_s <= 1'b0;
      seen   <= 1'b0;
    end else begin
      qual_s <= pix_qual_in;
      if (start_evt || h_fall) seen <= 1'b0;
      else if (h_now && qual_s) seen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      cnt        <= '0;
      line_valid <= 1'b0;
      first_line <= 1'b0;
    end else begin
      first_line <= 1'b0;
      if (start_evt) begin
        armed <= 1'b1;
        cnt   <= '0;
        if (cfg_line_offset == '0) begin
          line_valid <= 1'b1;
          first_line <= 1'b1;
        end else begin
          line_valid <= 1'b0;
        end
      end else if (line_done && !line_valid) begin
        cnt <= cnt + ONE;
        if (cnt + ONE == cfg_line_offset) begin
          line_valid <= 1'b1;
          first_line <= 1'b1;
        end
      end
    end
  end

  // R8: nothing opens before the first field start
  a_r8_idle_until_start: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!line_valid && !first_line));
  // R4: an HREF fall without a qualifier leaves the count alone
  a_r4_unqualified_line_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (h_fall && !seen && !start_evt) |=> $stable(cnt) && $stable(line_valid));
  // R5: a field start with non-zero offset closes the window
  a_r5_start_closes_window: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && cfg_line_offset != '0) |=> !line_valid);
  // R6: once open, the window holds until a field start
  a_r6_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && !start_evt) |=> line_valid);
endmodule

// File: rtl/vfd_top.sv
module vfd_top #(
  parameter int unsigned OFS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vsync_in,
  input  logic             href_in,
  input  logic             pix_qual_in,
  input  logic             cfg_fall_edge,
  input  logic             cfg_level_mode,
  input  logic [OFS_W-1:0] cfg_line_offset,
  output logic             field_start,
  output logic             field_odd,
  output logic             first_line,
  output logic             line_valid
);
  import vfd_pkg::*;

  logic [N_SIGS-1:0] raw, now, prev;
  logic              primed;
  logic              start_evt;

  assign raw[SIG_V] = vsync_in;
  assign raw[SIG_H] = href_in;

  vfd_edge_sync #(.N(N_SIGS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (raw),
    .now    (now),
    .prev   (prev),
    .primed (primed)
  );

  vfd_field_phase u_phase (
    .clk            (clk),
    .rst_n          (rst_n),
    .primed         (primed),
    .v_now          (now[SIG_V]),
    .v_prev         (prev[SIG_V]),
    .h_now          (now[SIG_H]),
    .cfg_fall_edge  (cfg_fall_edge),
    .cfg_level_mode (cfg_level_mode),
    .start_evt      (start_evt),
    .field_start    (field_start),
    .field_odd      (field_odd)
  );

  vfd_line_gate #(.OFS_W(OFS_W)) u_gate (
    .clk             (clk),
    .rst_n           (rst_n),
    .primed          (primed),
    .h_now           (now[SIG_H]),
    .h_prev          (prev[SIG_H]),
    .pix_qual_in     (pix_qual_in),
    .start_evt       (start_evt),
    .cfg_line_offset (cfg_line_offset),
    .line_valid      (line_valid),
    .first_line      (first_line)
  );

  // R2: in sync-pulse mode the field identity is HREF two edges back
  a_r2_odd_tracks_href: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && !cfg_level_mode) |-> field_odd == $past(href_in, 2));
  // R1: a field start always follows a real vertical transition
  a_r1_start_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |-> $past(vsync_in, 2) != $past(vsync_in, 3));
  // R7: zero offset opens the window together with the field start
  a_r7_zero_offset_open: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && cfg_line_offset == '0) |-> (line_valid && first_line));
endmodule

// File: tb/vfd_top_tb_top.sv
module vfd_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OFS_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsync_in = 1'b0, href_in = 1'b0, pix_qual_in = 1'b0;
  logic cfg_fall_edge = 1'b0, cfg_level_mode = 1'b0;
  logic [OFS_W-1:0] cfg_line_offset = '0;
  logic field_start, field_odd, first_line, line_valid;

  int checks = 0, fails = 0;
  int n_fs = 0, n_fl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vfd_top #(.OFS_W(OFS_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .href_in(href_in),
    .pix_qual_in(pix_qual_in), .cfg_fall_edge(cfg_fall_edge),
    .cfg_level_mode(cfg_level_mode), .cfg_line_offset(cfg_line_offset),
    .field_start(field_start), .field_odd(field_odd),
    .first_line(first_line), .line_valid(line_valid)
  );

  // pulse counters, sampled away from the active edge
  always @(negedge clk) begin
    if (field_start === 1'b1) n_fs++;
    if (first_line === 1'b1) n_fl++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic vedge(input logic val);
    vsync_in = val;
    step(3);
  endtask

  task automatic send_line(input bit qual);
    href_in = 1'b1;
    step(2);
    pix_qual_in = qual;
    step(1);
    pix_qual_in = 1'b0;
    step(2);
    href_in = 1'b0;
    step(4);
  endtask

  task automatic t_reset();
    step(3);
    chk({field_start, field_odd, first_line, line_valid} == 4'b0, "R9 reset",
        {field_start, field_odd, first_line, line_valid}, 0);
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic t_unarmed();
    cfg_line_offset = 1;
    send_line(1'b1);
    chk(line_valid == 1'b0, "R8 window before first start", line_valid, 0);
    chk(n_fl == 0, "R8 first_line before first start", n_fl, 0);
  endtask

  task automatic t_pulse_rise();
    int fs0;
    fs0 = n_fs;
    href_in = 1'b0;
    vedge(1'b1);
    chk(n_fs == fs0 + 1, "R1 rising edge starts field", n_fs, fs0 + 1);
    chk(field_odd == 1'b0, "R2 HREF low gives even", field_odd, 0);
    chk(line_valid == 1'b0, "R5 window closed after start", line_valid, 0);
    vedge(1'b0);
    chk(n_fs == fs0 + 1, "R1 falling edge ignored", n_fs, fs0 + 1);
    href_in = 1'b1;
    vedge(1'b1);
    chk(field_odd == 1'b1, "R2 HREF high gives odd", field_odd, 1);
    href_in = 1'b0;
    step(4);
    vedge(1'b0);
  endtask

  task automatic t_offset();
    int fl0;
    cfg_line_offset = 2;
    vedge(1'b1);
    vedge(1'b0);
    fl0 = n_fl;
    chk(line_valid == 1'b0, "R5 window closed at start", line_valid, 0);
    send_line(1'b1);
    chk(line_valid == 1'b0, "R6 one of two lines", line_valid, 0);
    send_line(1'b0);
    chk(line_valid == 1'b0, "R4 unqualified line not counted", line_valid, 0);
    send_line(1'b1);
    chk(line_valid == 1'b1, "R6 window opens on second qualified line", line_valid, 1);
    chk(n_fl == fl0 + 1, "R6 single first_line pulse", n_fl, fl0 + 1);
    send_line(1'b1);
    chk(line_valid == 1'b1 && n_fl == fl0 + 1, "R6 window holds, no new pulse", n_fl, fl0 + 1);
    vedge(1'b1);
    chk(line_valid == 1'b0, "R5 next start closes window", line_valid, 0);
    vedge(1'b0);
  endtask

  task automatic t_zero_offset();
    int fl0, fs0;
    cfg_line_offset = 0;
    fl0 = n_fl;
    fs0 = n_fs;
    vedge(1'b1);
    chk(line_valid == 1'b1, "R7 window opens at start", line_valid, 1);
    chk(n_fl == fl0 + 1 && n_fs == fs0 + 1, "R7 first_line with field_start", n_fl, fl0 + 1);
    vedge(1'b0);
  endtask

  task automatic t_fall_select();
    int fs0;
    cfg_line_offset = 2;
    cfg_fall_edge = 1'b1;
    step(2);
    fs0 = n_fs;
    vedge(1'b1);
    chk(n_fs == fs0, "R1 rising ignored with falling selected", n_fs, fs0);
    href_in = 1'b1;
    vedge(1'b0);
    chk(n_fs == fs0 + 1, "R1 falling edge starts field", n_fs, fs0 + 1);
    chk(field_odd == 1'b1, "R2 odd on falling edge", field_odd, 1);
    href_in = 1'b0;
    step(4);
  endtask

  task automatic t_level();
    int fs0;
    cfg_level_mode = 1'b1;
    cfg_fall_edge = 1'b0;
    step(2);
    fs0 = n_fs;
    vedge(1'b1);
    chk(field_odd == 1'b1, "R3 level high is odd", field_odd, 1);
    vedge(1'b0);
    chk(field_odd == 1'b0, "R3 level low is even", field_odd, 0);
    chk(n_fs == fs0 + 2, "R3 both edges start fields", n_fs, fs0 + 2);
    cfg_fall_edge = 1'b1;
    step(2);
    vedge(1'b1);
    chk(field_odd == 1'b0, "R3 inverted polarity high is even", field_odd, 0);
    vedge(1'b0);
    chk(field_odd == 1'b1, "R3 inverted polarity low is odd", field_odd, 1);
    chk(n_fs == fs0 + 4, "R3 four field starts", n_fs, fs0 + 4);
  endtask

  initial begin
    t_reset();
    t_unarmed();
    t_pulse_rise();
    t_offset();
    t_zero_offset();
    t_fall_select();
    t_level();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule